// File: doc/BRIEF.md
# Credit-Gated Packet-to-Flit Packer

This block is the sending end of a credit-controlled streaming link. Byte packets enter one byte per cycle, with a marker on the final byte, and are assembled into fixed-width flits. Each flit is divided into equal buckets. A packet always begins on a bucket boundary, and a packet longer than the room left in a flit runs on into the next one. Every flit carries masks and pointers that describe where packets begin and end inside it, so the far side can split the flit back into packets.

The receiver hands credits back as a count. The packer adds these credits to a counter. A finished flit leaves only when an open burst still has allowance, or when the counter has reached the configured burst length and can fund a new burst. While a finished flit waits for credit, the byte input is stalled.

Top module: `flit_packer`

## Requirements
- R1: The bucket size is FLIT_BYTES / PKTS_PER_FLIT bytes (4 with the defaults). Byte k of a flit occupies out_data[8k+7:8k]. The first packet of an empty flit begins at byte 0.
- R2: When a packet's first byte enters a flit, the lowest clear bit of out_start_mask is set. The matching 2-bit slot of out_start_ptr (slot i at bits [2i+1:2i]) receives the bucket index where that packet begins.
- R3: When a packet's last byte enters a flit, the lowest clear bit of out_end_mask is set. The matching end-pointer slot receives ((e + 1) / 4) − 1 in integer arithmetic, where e is the byte offset just past that last byte. A negative result is written as 0.
- R4: A packet that fills the last byte of a flit continues at byte 0 of the next flit. No start bit is set for it in that next flit.
- R5: After a packet ends, the next packet begins at the next bucket boundary. When no bucket remains, the flit is finished without waiting for more input.
- R6: A flit that holds at least one byte and no unfinished packet is finished in any cycle where in_valid is low.
- R7: Each cycle with cr_valid high adds cr_amount to the credit counter. Counts from successive credit messages accumulate.
- R8: A finished flit is issued only if the burst allowance is nonzero or the credit counter is at least BURST_LEN. Otherwise it waits, and in_ready stays low while it waits.
- R9: Issuing a flit with zero allowance starts a burst: BURST_LEN is taken from the counter, and the allowance becomes BURST_LEN − 1. Issuing a flit with nonzero allowance lowers the allowance by one and leaves the counter untouched.
- R10: In an issued flit, unused pointer slots and unused data bytes are zero. Both masks are filled from bit 0 upward with no gaps.
- R11: out_valid is high for exactly the one cycle after the issue decision. After reset, out_valid is low, in_ready is high, and the counter, allowance and any partly packed packet are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Byte accepted on this edge when high with in_valid |
| in_byte | input | 8 | Packet byte |
| in_last | input | 1 | Marks the final byte of a packet |
| cr_valid | input | 1 | Credit message present |
| cr_amount | input | 8 | Number of credits returned |
| out_valid | output | 1 | Flit issued this cycle |
| out_data | output | FLIT_BYTES*8 | Flit payload |
| out_start_mask | output | PKTS_PER_FLIT | One bit per packet starting in the flit |
| out_start_ptr | output | PKTS_PER_FLIT*log2(PKTS_PER_FLIT) | Start bucket index per slot |
| out_end_mask | output | PKTS_PER_FLIT | One bit per packet ending in the flit |
| out_end_ptr | output | PKTS_PER_FLIT*log2(FLIT_BYTES/4) | End position in 4-byte units per slot |

## Verification
The hardest case to reach from the ports is a flit that is ready but held because an open burst has just run dry while the counter sits below the threshold. Reaching it requires a chain of earlier flits that spend credit in a known pattern. The bench therefore follows one credit ledger across every scenario in order. Credits are handed out in amounts that leave, at planned points, a full allowance, an empty allowance with a small counter, or a counter that just reaches the threshold. At each such point the bench confirms that no flit appears and that in_ready stays low until the last credit arrives.

// File: rtl/flit_packer_pkg.sv
package flit_packer_pkg;
  // round a byte offset up to the next bucket boundary
  function automatic int align_up(input int off, input int bkt);
    return ((off + bkt - 1) / bkt) * bkt;
  endfunction

  // end pointer in 4-byte units from the offset just past the last byte
  function automatic int end_ptr_units(input int end_excl);
    int v;
    v = (end_excl + 1) / 4 - 1;
    return (v < 0) ? 0 : v;
  endfunction
endpackage

// File: rtl/fp_credit_gate.sv
module fp_credit_gate #(
  parameter int CW    = 12,
  parameter int BURST = 2,
  parameter int AW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cr_valid,
  input  logic [7:0]    cr_amount,
  input  logic          want,
  output logic          send,
  output logic          burst_start,
  output logic [CW-1:0] credit_cnt,
  output logic [AW-1:0] allow_cnt
);
  logic [CW-1:0] add_w, sub_w;

  assign send        = want && ((allow_cnt != '0) || (credit_cnt >= CW'(BURST)));
  assign burst_start = send && (allow_cnt == '0);
  assign add_w       = cr_valid ? CW'(cr_amount) : '0;
  assign sub_w       = burst_start ? CW'(BURST) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      credit_cnt <= '0;
      allow_cnt  <= '0;
    end else begin
      credit_cnt <= credit_cnt + add_w - sub_w;
      if (burst_start)   allow_cnt <= AW'(BURST - 1);
      else if (send)     allow_cnt <= allow_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/fp_flit_builder.sv
module fp_flit_builder
  import flit_packer_pkg::*;
#(
  parameter int FB = 16,
  parameter int NP = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [7:0]               in_byte,
  input  logic                     in_last,
  input  logic                     take,
  output logic                     held,
  output logic [FB*8-1:0]          data,
  output logic [NP-1:0]            smask,
  output logic [NP*$clog2(NP)-1:0] sptr,
  output logic [NP-1:0]            emask,
  output logic [NP*$clog2(FB/4)-1:0] eptr
);
  localparam int BKT = FB / NP;
  localparam int PW  = $clog2(FB);
  localparam int SPW = $clog2(NP);
  localparam int EPW = $clog2(FB / 4);

  logic [PW-1:0]  pos_q;
  logic           mid_q, held_q;
  logic [SPW-1:0] sidx_q, eidx_q;
  logic           accept, flush;
  int             end_excl, nxt;

  assign accept = in_valid && !held_q;
  assign flush  = !in_valid && !held_q && !mid_q && (pos_q != '0);
  assign held   = held_q;

  always_comb begin
    end_excl = int'(pos_q) + 1;
    nxt      = align_up(end_excl, BKT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0; mid_q <= 1'b0; held_q <= 1'b0;
      sidx_q <= '0; eidx_q <= '0;
      data <= '0; smask <= '0; sptr <= '0; emask <= '0; eptr <= '0;
    end else if (take) begin
      held_q <= 1'b0;
      sidx_q <= '0; eidx_q <= '0;
      data <= '0; smask <= '0; sptr <= '0; emask <= '0; eptr <= '0;
    end else if (accept) begin
      data[pos_q*8 +: 8] <= in_byte;
      if (!mid_q) begin
        smask[sidx_q]            <= 1'b1;
        sptr[sidx_q*SPW +: SPW]  <= SPW'(int'(pos_q) / BKT);
        sidx_q                   <= sidx_q + 1'b1;
      end
      if (in_last) begin
        emask[eidx_q]            <= 1'b1;
        eptr[eidx_q*EPW +: EPW]  <= EPW'(end_ptr_units(end_excl));
        eidx_q                   <= eidx_q + 1'b1;
        mid_q                    <= 1'b0;
        if (nxt >= FB) begin
          held_q <= 1'b1;
          pos_q  <= '0;
        end else begin
          pos_q  <= PW'(nxt);
        end
      end else begin
        mid_q <= 1'b1;
        if (end_excl >= FB) begin
          held_q <= 1'b1;
          pos_q  <= '0;
        end else begin
          pos_q  <= pos_q + 1'b1;
        end
      end
    end else if (flush) begin
      held_q <= 1'b1;
      pos_q  <= '0;
    end
  end
endmodule

// File: rtl/flit_packer.sv
module flit_packer #(
  parameter int FLIT_BYTES    = 16,
  parameter int PKTS_PER_FLIT = 4,
  parameter int BURST_LEN     = 2,
  parameter int CREDIT_W      = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [7:0]            in_byte,
  input  logic                  in_last,
  input  logic                  cr_valid,
  input  logic [7:0]            cr_amount,
  output logic                  out_valid,
  output logic [FLIT_BYTES*8-1:0] out_data,
  output logic [PKTS_PER_FLIT-1:0] out_start_mask,
  output logic [PKTS_PER_FLIT*$clog2(PKTS_PER_FLIT)-1:0] out_start_ptr,
  output logic [PKTS_PER_FLIT-1:0] out_end_mask,
  output logic [PKTS_PER_FLIT*$clog2(FLIT_BYTES/4)-1:0] out_end_ptr
);
  localparam int SPW = $clog2(PKTS_PER_FLIT);
  localparam int EPW = $clog2(FLIT_BYTES / 4);
  localparam int AW  = $clog2(BURST_LEN + 1);

  logic                      flit_held, send_evt, burst_evt;
  logic [CREDIT_W-1:0]       credit_cnt;
  logic [AW-1:0]             allow_cnt;
  logic [FLIT_BYTES*8-1:0]   bld_data;
  logic [PKTS_PER_FLIT-1:0]  bld_smask, bld_emask;
  logic [PKTS_PER_FLIT*SPW-1:0] bld_sptr;
  logic [PKTS_PER_FLIT*EPW-1:0] bld_eptr;

  fp_flit_builder #(.FB(FLIT_BYTES), .NP(PKTS_PER_FLIT)) u_build (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_last(in_last), .take(send_evt), .held(flit_held), .data(bld_data),
    .smask(bld_smask), .sptr(bld_sptr), .emask(bld_emask), .eptr(bld_eptr)
  );

  fp_credit_gate #(.CW(CREDIT_W), .BURST(BURST_LEN), .AW(AW)) u_gate (
    .clk(clk), .rst_n(rst_n), .cr_valid(cr_valid), .cr_amount(cr_amount),
    .want(flit_held), .send(send_evt), .burst_start(burst_evt),
    .credit_cnt(credit_cnt), .allow_cnt(allow_cnt)
  );

  assign in_ready = !flit_held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data <= '0; out_start_mask <= '0; out_start_ptr <= '0;
      out_end_mask <= '0; out_end_ptr <= '0;
    end else begin
      out_valid <= send_evt;
      if (send_evt) begin
        out_data       <= bld_data;
        out_start_mask <= bld_smask;
        out_start_ptr  <= bld_sptr;
        out_end_mask   <= bld_emask;
        out_end_ptr    <= bld_eptr;
      end
    end
  end
endmodule

// File: rtl/fp_checker.sv
module fp_checker #(
  parameter int NP    = 4,
  parameter int SPW   = 2,
  parameter int EPW   = 2,
  parameter int CW    = 12,
  parameter int AW    = 2,
  parameter int BURST = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          cr_valid,
  input logic          out_valid,
  input logic [NP-1:0] out_start_mask,
  input logic [NP*SPW-1:0] out_start_ptr,
  input logic [NP-1:0] out_end_mask,
  input logic [NP*EPW-1:0] out_end_ptr,
  input logic          flit_held,
  input logic          send_evt,
  input logic [CW-1:0] credit_cnt,
  input logic [AW-1:0] allow_cnt
);
  AST_HELD_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    flit_held |-> !in_ready); // R8
  AST_BURST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (send_evt && allow_cnt == '0) |=> (allow_cnt == AW'(BURST - 1))); // R9
  AST_ALLOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (send_evt && allow_cnt != '0) |=> (allow_cnt == $past(allow_cnt) - 1'b1)); // R9
  AST_COUNT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!send_evt && !cr_valid) |=> $stable(credit_cnt)); // R7
  AST_ISSUE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    send_evt |=> out_valid); // R11
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !send_evt |=> !out_valid); // R11
  AST_START_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (((out_start_mask + 1'b1) & out_start_mask) == '0)); // R10
  AST_END_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (((out_end_mask + 1'b1) & out_end_mask) == '0)); // R10
  AST_TOP_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_end_mask[NP-1]) |-> (out_end_ptr[NP*EPW-1 -: EPW] == '0)); // R10
  AST_TOP_SSLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_start_mask[NP-1]) |-> (out_start_ptr[NP*SPW-1 -: SPW] == '0)); // R10
endmodule

bind flit_packer fp_checker #(
  .NP(PKTS_PER_FLIT), .SPW(SPW), .EPW(EPW), .CW(CREDIT_W), .AW(AW), .BURST(BURST_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .cr_valid(cr_valid),
  .out_valid(out_valid), .out_start_mask(out_start_mask), .out_start_ptr(out_start_ptr),
  .out_end_mask(out_end_mask), .out_end_ptr(out_end_ptr), .flit_held(flit_held),
  .send_evt(send_evt), .credit_cnt(credit_cnt), .allow_cnt(allow_cnt)
);

// File: tb/flit_packer_bench.sv
module flit_packer_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, cr_valid = 1'b0;
  logic [7:0] in_byte = '0, cr_amount = '0;
  logic in_ready, out_valid;
  logic [127:0] out_data;
  logic [3:0] out_start_mask, out_end_mask;
  logic [7:0] out_start_ptr, out_end_ptr;

  int checks = 0, fails = 0, fcount = 0;
  bit done = 0;
  logic [127:0] cap_data [8];
  logic [3:0]   cap_sm [8], cap_em [8];
  logic [7:0]   cap_sp [8], cap_ep [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  flit_packer u_flit_packer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_last(in_last), .cr_valid(cr_valid), .cr_amount(cr_amount),
    .out_valid(out_valid), .out_data(out_data), .out_start_mask(out_start_mask),
    .out_start_ptr(out_start_ptr), .out_end_mask(out_end_mask), .out_end_ptr(out_end_ptr)
  );

  always @(negedge clk) begin
    if (out_valid && fcount < 8) begin
      cap_data[fcount] = out_data;
      cap_sm[fcount] = out_start_mask; cap_sp[fcount] = out_start_ptr;
      cap_em[fcount] = out_end_mask;   cap_ep[fcount] = out_end_ptr;
      fcount++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // end position in 4-byte units, clamped at zero
  function automatic logic [1:0] ep(input int e);
    if (e < 3) return 2'd0;
    return 2'((e + 1) / 4 - 1);
  endfunction

  task automatic push_byte(input logic [7:0] b, input bit last);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_byte = b; in_last = last;
    @(posedge clk);
  endtask

  task automatic push_pkt(input int len, input logic [7:0] base);
    for (int i = 0; i < len; i++) push_byte(base + 8'(i), i == len - 1);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic give(input logic [7:0] n);
    @(negedge clk);
    cr_valid = 1'b1; cr_amount = n;
    @(negedge clk);
    cr_valid = 1'b0; cr_amount = '0;
  endtask

  task automatic expect_held(input string req, input int seen);
    repeat (20) @(negedge clk);
    chk(fcount == seen, req, 128'(fcount), 128'(seen));
    chk(in_ready == 1'b0, req, 128'(in_ready), 128'(0));
  endtask

  task automatic expect_flit(input int idx, input string req, input logic [127:0] d,
                             input logic [3:0] sm, input logic [7:0] sp,
                             input logic [3:0] em, input logic [7:0] epv);
    int t = 0;
    while (fcount <= idx && t < 300) begin @(negedge clk); t++; end
    chk(fcount > idx, {req, " flit arrival"}, 128'(fcount), 128'(idx + 1));
    if (fcount > idx) begin
      chk(cap_data[idx] == d,  {req, " data"},       cap_data[idx], d);
      chk(cap_sm[idx] == sm,   {req, " start mask"}, 128'(cap_sm[idx]), 128'(sm));
      chk(cap_sp[idx] == sp,   {req, " start ptr"},  128'(cap_sp[idx]), 128'(sp));
      chk(cap_em[idx] == em,   {req, " end mask"},   128'(cap_em[idx]), 128'(em));
      chk(cap_ep[idx] == epv,  {req, " end ptr"},    128'(cap_ep[idx]), 128'(epv));
    end
  endtask

  function automatic logic [127:0] bytes_at(input logic [127:0] acc, input int off,
                                            input int len, input logic [7:0] base);
    logic [127:0] r = acc;
    for (int i = 0; i < len; i++) r[(off + i)*8 +: 8] = base + 8'(i);
    return r;
  endfunction

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11 reset out_valid", 128'(out_valid), 128'(0));
    chk(in_ready == 1'b1, "R11 reset in_ready", 128'(in_ready), 128'(1));
  endtask

  // one bucket packet, flushed on idle, held until credits reach the threshold
  task automatic t_single();
    push_pkt(4, 8'h10); idle();
    expect_held("R8 no credit", 0);
    give(8'd1);
    expect_held("R7 R8 below threshold", 0);
    give(8'd1);
    expect_flit(0, "R6 R1 R2 R3 R10 single", bytes_at('0, 0, 4, 8'h10),
                4'b0001, 8'h00, 4'b0001, {6'd0, ep(4)});
  endtask

  // full flit issued from the remaining burst allowance
  task automatic t_full();
    push_pkt(16, 8'h80); idle();
    expect_flit(1, "R9 allowance spend", bytes_at('0, 0, 16, 8'h80),
                4'b0001, 8'h00, 4'b0001, {6'd0, ep(16)});
  endtask

  // two packets share a flit, second aligned to next bucket
  task automatic t_pair();
    push_pkt(5, 8'h20); push_pkt(6, 8'h30); idle();
    expect_held("R9 allowance exhausted", 2);
    give(8'd5);
    expect_flit(2, "R5 R2 R3 pair", bytes_at(bytes_at('0, 0, 5, 8'h20), 8, 6, 8'h30),
                4'b0011, {4'd0, 2'd2, 2'd0}, 4'b0011, {4'd0, ep(14), ep(5)});
  endtask

  // packet running across two flits
  task automatic t_carry();
    push_pkt(20, 8'h40); idle();
    expect_flit(3, "R4 carry first", bytes_at('0, 0, 16, 8'h40),
                4'b0001, 8'h00, 4'b0000, 8'h00);
    expect_flit(4, "R4 R9 carry second", bytes_at('0, 0, 4, 8'h50),
                4'b0000, 8'h00, 4'b0001, {6'd0, ep(4)});
  endtask

  // tiny packet clamps end pointer; four packets fill every bucket
  task automatic t_edges();
    push_pkt(1, 8'h70); idle();
    expect_flit(5, "R3 clamp", bytes_at('0, 0, 1, 8'h70),
                4'b0001, 8'h00, 4'b0001, 8'h00);
    for (int k = 0; k < 4; k++) push_pkt(4, 8'h60 + 8'(4*k));
    idle();
    expect_held("R8 counter below burst", 6);
    give(8'd1);
    expect_flit(6, "R5 R2 R3 four packets", bytes_at('0, 0, 16, 8'h60),
                4'b1111, 8'he4, 4'b1111, {ep(16), ep(12), ep(8), ep(4)});
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    t_reset();
    t_single();
    t_full();
    t_pair();
    t_carry();
    t_edges();
    repeat (5) @(negedge clk);
    finish_up();
  end
endmodule